// File: doc/BRIEF.md
# PHY Error Statistics Counter Bank

This block holds the error statistics of an Ethernet PHY management unit and makes them readable through a small synchronous register port. It counts five kinds of events: invalid code groups seen while the receiver is in sync, false carrier events, local receiver-not-OK episodes, remote receiver-not-OK episodes, and CRC errors. Every counter stops at its all-ones value instead of wrapping. Most counters clear when software reads them. The invalid-code-group counter ignores reads and is cleared only by an explicit write to an expansion control address.

Each event source supplies one 7-bit event vector, one from the SerDes path and one from the copper path. The bit map is the same for both: [0] invalid code group strobe, [1] sync status level, [2] false carrier strobe, [3] received-packet-with-transmit-error-code strobe, [4] CRC error strobe, [5] local receiver OK level, [6] remote receiver OK level. A control register chooses which vector feeds the counters. It also holds two test bits. One makes the false carrier counter count packets that carry transmit error codes instead. The other makes the receiver-status address show a 16-bit CRC error counter.

Address map (4-bit address): 0x0 status word, {invalid code groups[15:8], false carrier[7:0]}. 0x1 receiver word, {local not-OK[15:8], remote not-OK[7:0]}, or the CRC counter in CRC test mode. 0x2 control, with bit 0 = source select (1 SerDes, 0 copper), bit 1 = transmit-error visibility, bit 2 = CRC visibility. 0x3 expansion control, write only, where bit 15 = 1 clears the invalid-code-group counter.

Top module: `phy_err_stats`

## Requirements
- R1: After reset every counter and the control register are zero, and reads of 0x0, 0x1 and 0x2 return 0x0000.
- R2: A read strobe gives read data valid for exactly one cycle, in the next cycle. The data is the addressed word's value in the strobe cycle, taken before any clear-on-read.
- R3: The 8-bit invalid-code-group counter in 0x0[15:8] counts code group strobes only while sync status is 1. Reads do not clear it. It holds at 0xFF. A write to 0x3 with bit 15 = 1 clears it, and a write with bit 15 = 0 leaves it unchanged.
- R4: The 8-bit false carrier counter in 0x0[7:0] counts false carrier strobes, holds at 0xFF, and clears on a read of 0x0.
- R5: With control bit 1 set, the false carrier counter counts transmit-error-code packet strobes and ignores false carrier strobes.
- R6: The local and remote receiver-not-OK counters in 0x1 rise by one on each change of their OK level from 1 to 0. They do not count per cycle. Each holds at 0xFF, and both clear on a read of 0x1 outside CRC test mode.
- R7: With control bit 2 set, 0x1 returns a 16-bit CRC counter. That counter counts CRC strobes only in this mode, holds at 0xFFFF, and clears on a read of 0x1 in this mode. Such a read leaves the receiver counters unchanged.
- R8: With control bit 0 set, all counters take their events from the SerDes vector. With bit 0 clear they take them from the copper vector, and the other vector is ignored.
- R9: An event in the same cycle as that counter's clear leaves the counter at 1.
- R10: The control register reads back at 0x2[2:0]. Writing it does not change any counter, and writes to 0x0 and 0x1 are ignored.
- R11: Reads of unmapped addresses return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_wr_en | input | 1 | Write enable |
| reg_wr_data | input | 16 | Write data |
| reg_rd_stb | input | 1 | Read strobe |
| reg_rd_data | output | 16 | Read data, held between reads |
| reg_rd_valid | output | 1 | Read data valid, one cycle after strobe |
| sd_evt | input | 7 | SerDes event vector |
| cu_evt | input | 7 | Copper event vector |

## Verification
Counter state can only be seen through register reads, so a wrong value shows up in the read data of the first read after the faulty event. That is one cycle after the strobe. A missed clear-on-read shows up as a nonzero value on the following read of the same word. A clear that wrongly reaches another counter shows as a drop in that counter's next read. An event lost in a clear cycle shows as zero where one is expected. A wrong source or test-mode steering shows as counts that follow the wrong input vector.

// File: rtl/phy_err_stats_pkg.sv
package phy_err_stats_pkg;
  localparam int ADDR_STAT  = 0;
  localparam int ADDR_RXNOK = 1;
  localparam int ADDR_CTRL  = 2;
  localparam int ADDR_EXP   = 3;

  localparam int EVT_W     = 7;
  localparam int EV_CODE   = 0;
  localparam int EV_SYNC   = 1;
  localparam int EV_FCAR   = 2;
  localparam int EV_TXERR  = 3;
  localparam int EV_CRC    = 4;
  localparam int EV_LOC_OK = 5;
  localparam int EV_REM_OK = 6;

  localparam int CTRL_W      = 3;
  localparam int CTRL_SRC    = 0;
  localparam int CTRL_TXVIS  = 1;
  localparam int CTRL_CRCVIS = 2;
endpackage

// File: rtl/phy_err_satctr.sv
module phy_err_satctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (clr) begin
      cnt_n = inc ? ONE : '0;
    end else if (inc && (cnt_q != MAXV)) begin
      cnt_n = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/phy_err_episode.sv
module phy_err_episode (
  input  logic clk,
  input  logic rst_n,
  input  logic ok,
  output logic drop
);
  logic ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_q <= 1'b1;
    else        ok_q <= ok;
  end

  assign drop = ok_q & ~ok;
endmodule

// File: rtl/phy_err_stats.sv
module phy_err_stats
  import phy_err_stats_pkg::*;
#(
  parameter int AW   = 4,
  parameter int DW   = 16,
  parameter int CW   = 8,
  parameter int CRCW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_wr_en,
  input  logic [DW-1:0]    reg_wr_data,
  input  logic             reg_rd_stb,
  output logic [DW-1:0]    reg_rd_data,
  output logic             reg_rd_valid,
  input  logic [EVT_W-1:0] sd_evt,
  input  logic [EVT_W-1:0] cu_evt
);
  localparam int NRX = 2;

  logic [CTRL_W-1:0] ctrl_q, ctrl_n;
  logic [EVT_W-1:0]  evt;
  logic              hit_stat, hit_rx, hit_ctrl, hit_exp;
  logic              clr_cg, clr_fc, clr_rx, clr_crc;
  logic              inc_cg, inc_fc, inc_crc;
  logic [CW-1:0]     cg_cnt, fc_cnt;
  logic [CRCW-1:0]   crc_cnt;
  logic [NRX-1:0]    rx_ok, rx_drop;
  logic [CW-1:0]     rx_cnt [NRX];
  logic [DW-1:0]     rd_word, rd_data_q, rd_data_n;
  logic              rd_valid_q;
  logic              unused_wr;

  assign unused_wr = ^reg_wr_data[DW-2:CTRL_W];

  assign evt = ctrl_q[CTRL_SRC] ? sd_evt : cu_evt;

  assign hit_stat = (reg_addr == AW'(ADDR_STAT));
  assign hit_rx   = (reg_addr == AW'(ADDR_RXNOK));
  assign hit_ctrl = (reg_addr == AW'(ADDR_CTRL));
  assign hit_exp  = (reg_addr == AW'(ADDR_EXP));

  assign clr_cg  = reg_wr_en && hit_exp && reg_wr_data[DW-1];
  assign clr_fc  = reg_rd_stb && hit_stat;
  assign clr_rx  = reg_rd_stb && hit_rx && !ctrl_q[CTRL_CRCVIS];
  assign clr_crc = reg_rd_stb && hit_rx && ctrl_q[CTRL_CRCVIS];

  assign inc_cg  = evt[EV_CODE] & evt[EV_SYNC];
  assign inc_fc  = ctrl_q[CTRL_TXVIS] ? evt[EV_TXERR] : evt[EV_FCAR];
  assign inc_crc = evt[EV_CRC] & ctrl_q[CTRL_CRCVIS];

  // control register
  always_comb begin
    ctrl_n = ctrl_q;
    if (reg_wr_en && hit_ctrl) ctrl_n = reg_wr_data[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_n;
  end

  phy_err_satctr #(.W(CW)) u_cg (
    .clk(clk), .rst_n(rst_n), .inc(inc_cg), .clr(clr_cg), .cnt(cg_cnt)
  );

  phy_err_satctr #(.W(CW)) u_fc (
    .clk(clk), .rst_n(rst_n), .inc(inc_fc), .clr(clr_fc), .cnt(fc_cnt)
  );

  phy_err_satctr #(.W(CRCW)) u_crc (
    .clk(clk), .rst_n(rst_n), .inc(inc_crc), .clr(clr_crc), .cnt(crc_cnt)
  );

  // index 1 = local receiver, index 0 = remote receiver
  assign rx_ok = {evt[EV_LOC_OK], evt[EV_REM_OK]};

  for (genvar g = 0; g < NRX; g++) begin : g_rx
    phy_err_episode u_ep (
      .clk(clk), .rst_n(rst_n), .ok(rx_ok[g]), .drop(rx_drop[g])
    );
    phy_err_satctr #(.W(CW)) u_ctr (
      .clk(clk), .rst_n(rst_n), .inc(rx_drop[g]), .clr(clr_rx), .cnt(rx_cnt[g])
    );
  end

  // read mux
  always_comb begin
    rd_word = '0;
    if (hit_stat) begin
      rd_word[2*CW-1:0] = {cg_cnt, fc_cnt};
    end else if (hit_rx) begin
      if (ctrl_q[CTRL_CRCVIS]) rd_word[CRCW-1:0]  = crc_cnt;
      else                     rd_word[2*CW-1:0] = {rx_cnt[1], rx_cnt[0]};
    end else if (hit_ctrl) begin
      rd_word[CTRL_W-1:0] = ctrl_q;
    end
  end

  always_comb begin
    rd_data_n = rd_data_q;
    if (reg_rd_stb) rd_data_n = rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_data_q  <= rd_data_n;
      rd_valid_q <= reg_rd_stb;
    end
  end

  assign reg_rd_data  = rd_data_q;
  assign reg_rd_valid = rd_valid_q;
endmodule

// File: rtl/phy_err_stats_chk.sv
module phy_err_stats_chk #(
  parameter int CW   = 8,
  parameter int CRCW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_stb,
  input logic            rd_valid,
  input logic            clr_cg,
  input logic            clr_fc,
  input logic            clr_rx,
  input logic            clr_crc,
  input logic [CW-1:0]   cg,
  input logic [CW-1:0]   fc,
  input logic [CW-1:0]   loc,
  input logic [CRCW-1:0] crc
);
  localparam logic [CW-1:0]   CMAX = {CW{1'b1}};
  localparam logic [CRCW-1:0] KMAX = {CRCW{1'b1}};

  assert_rd_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid);

  assert_rd_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rd_valid);

  assert_cg_no_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_cg |=> cg >= $past(cg));

  assert_fc_no_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_fc |=> fc >= $past(fc));

  assert_fc_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fc == CMAX && !clr_fc) |=> fc == CMAX);

  assert_loc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_rx |=> (loc == $past(loc)) || (loc == $past(loc) + 1'b1));

  assert_crc_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (crc == KMAX && !clr_crc) |=> crc == KMAX);

  assert_clr_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fc |=> fc <= 1);
endmodule

bind phy_err_stats phy_err_stats_chk #(.CW(CW), .CRCW(CRCW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_stb(reg_rd_stb), .rd_valid(reg_rd_valid),
  .clr_cg(clr_cg), .clr_fc(clr_fc), .clr_rx(clr_rx), .clr_crc(clr_crc),
  .cg(cg_cnt), .fc(fc_cnt), .loc(rx_cnt[1]), .crc(crc_cnt)
);

// File: tb/phy_err_stats_tb_top.sv
module phy_err_stats_tb_top;
  logic        clk;
  logic        rst_n;
  logic [3:0]  reg_addr;
  logic        reg_wr_en;
  logic [15:0] reg_wr_data;
  logic        reg_rd_stb;
  logic [15:0] reg_rd_data;
  logic        reg_rd_valid;
  logic [6:0]  sd_evt;
  logic [6:0]  cu_evt;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] d;

  localparam int B_CODE = 0, B_SYNC = 1, B_FCAR = 2, B_TXE = 3, B_CRC = 4, B_LOC = 5, B_REM = 6;

  phy_err_stats dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_stb(reg_rd_stb), .reg_rd_data(reg_rd_data),
    .reg_rd_valid(reg_rd_valid), .sd_evt(sd_evt), .cu_evt(cu_evt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [3:0] a, input logic [6:0] cmask, output logic [15:0] q);
    @(negedge clk);
    reg_addr = a; reg_rd_stb = 1'b1; cu_evt = cu_evt ^ cmask;
    @(negedge clk);
    reg_rd_stb = 1'b0; cu_evt = cu_evt ^ cmask;
    q = reg_rd_data;
    chk("R2 valid after strobe", {15'd0, reg_rd_valid}, 16'd1);
    @(negedge clk);
    chk("R2 valid one cycle", {15'd0, reg_rd_valid}, 16'd0);
  endtask

  task automatic do_write(input logic [3:0] a, input logic [15:0] v, input logic [6:0] cmask);
    @(negedge clk);
    reg_addr = a; reg_wr_data = v; reg_wr_en = 1'b1; cu_evt = cu_evt ^ cmask;
    @(negedge clk);
    reg_wr_en = 1'b0; cu_evt = cu_evt ^ cmask;
  endtask

  task automatic pulse(input bit sd, input int b, input int n);
    if (n > 0) begin
      @(negedge clk);
      if (sd) sd_evt[b] = 1'b1; else cu_evt[b] = 1'b1;
      repeat (n) @(negedge clk);
      if (sd) sd_evt[b] = 1'b0; else cu_evt[b] = 1'b0;
    end
  endtask

  task automatic episodes(input int b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cu_evt[b] = 1'b0;
      @(negedge clk); @(negedge clk); cu_evt[b] = 1'b1;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr_en = 1'b0; reg_wr_data = '0; reg_rd_stb = 1'b0;
    cu_evt = 7'b1100000; sd_evt = 7'b1100000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    do_read(4'h0, 7'd0, d); chk("R1 reset stat", d, 16'h0000);
    do_read(4'h1, 7'd0, d); chk("R1 reset rx", d, 16'h0000);
    do_read(4'h2, 7'd0, d); chk("R1 reset ctrl", d, 16'h0000);

    // R4 sweep with saturation
    for (int n = 0; n <= 260; n++) begin
      pulse(0, B_FCAR, n);
      do_read(4'h0, 7'd0, d);
      chk("R4 false carrier count", d, (n > 255) ? 16'h00FF : 16'(n));
    end

    // R3 invalid code group counter
    pulse(0, B_CODE, 5);
    do_read(4'h0, 7'd0, d); chk("R3 no count without sync", d, 16'h0000);
    cu_evt[B_SYNC] = 1'b1;
    pulse(0, B_CODE, 7);
    do_read(4'h0, 7'd0, d); chk("R3 count in sync", d, 16'h0700);
    do_read(4'h0, 7'd0, d); chk("R3 not cleared by read", d, 16'h0700);
    pulse(0, B_CODE, 260);
    do_read(4'h0, 7'd0, d); chk("R3 saturate", d, 16'hFF00);
    do_write(4'h3, 16'h7FFF, 7'd0);
    do_read(4'h0, 7'd0, d); chk("R3 write bit15=0 keeps", d, 16'hFF00);
    do_write(4'h3, 16'h8000, 7'd0);
    do_read(4'h0, 7'd0, d); chk("R3 write bit15=1 clears", d, 16'h0000);

    // R5 transmit error visibility
    do_write(4'h2, 16'h0002, 7'd0);
    pulse(0, B_FCAR, 3); pulse(0, B_TXE, 4);
    do_read(4'h0, 7'd0, d); chk("R5 counts tx error packets", d, 16'h0004);
    do_write(4'h2, 16'h0000, 7'd0);
    pulse(0, B_TXE, 2); pulse(0, B_FCAR, 1);
    do_read(4'h0, 7'd0, d); chk("R5 normal mode ignores tx error", d, 16'h0001);

    // R6 episodes
    episodes(B_LOC, 3); episodes(B_REM, 2);
    do_read(4'h1, 7'd0, d); chk("R6 episode counts", d, 16'h0302);
    do_read(4'h1, 7'd0, d); chk("R6 clear on read", d, 16'h0000);
    episodes(B_LOC, 260);
    do_read(4'h1, 7'd0, d); chk("R6 saturate", d, 16'hFF00);

    // R7 CRC test mode
    episodes(B_LOC, 1);
    do_write(4'h2, 16'h0004, 7'd0);
    pulse(0, B_CRC, 7); episodes(B_LOC, 1);
    do_read(4'h1, 7'd0, d); chk("R7 crc count", d, 16'h0007);
    do_read(4'h1, 7'd0, d); chk("R7 crc clear on read", d, 16'h0000);
    do_write(4'h2, 16'h0000, 7'd0);
    do_read(4'h1, 7'd0, d); chk("R7 receiver counters kept", d, 16'h0200);
    pulse(0, B_CRC, 5);
    do_write(4'h2, 16'h0004, 7'd0);
    do_read(4'h1, 7'd0, d); chk("R7 no crc count outside mode", d, 16'h0000);
    pulse(0, B_CRC, 65600);
    do_read(4'h1, 7'd0, d); chk("R7 crc saturate", d, 16'hFFFF);
    do_read(4'h1, 7'd0, d); chk("R7 crc cleared", d, 16'h0000);

    // R8 source select
    do_write(4'h2, 16'h0001, 7'd0);
    sd_evt[B_SYNC] = 1'b1;
    pulse(0, B_FCAR, 3); pulse(1, B_FCAR, 2);
    pulse(0, B_CODE, 6); pulse(1, B_CODE, 4);
    do_read(4'h0, 7'd0, d); chk("R8 serdes selected", d, 16'h0402);
    do_write(4'h2, 16'h0000, 7'd0);
    pulse(1, B_FCAR, 5);
    do_read(4'h0, 7'd0, d); chk("R8 copper selected", d, 16'h0400);
    do_read(4'h1, 7'd0, d); chk("R8 no spurious episode", d, 16'h0000);
    do_write(4'h3, 16'h8000, 7'd0);

    // R9 event coincident with clear
    pulse(0, B_FCAR, 3);
    do_read(4'h0, 7'(1 << B_FCAR), d); chk("R9 read value before clear", d, 16'h0003);
    do_read(4'h0, 7'd0, d); chk("R9 event kept on read clear", d, 16'h0001);
    pulse(0, B_CODE, 2);
    do_write(4'h3, 16'h8000, 7'(1 << B_CODE));
    do_read(4'h0, 7'd0, d); chk("R9 event kept on write clear", d, 16'h0100);
    do_write(4'h3, 16'h8000, 7'd0);

    // R10 control and write isolation
    do_write(4'h2, 16'h0005, 7'd0);
    do_read(4'h2, 7'd0, d); chk("R10 ctrl readback", d, 16'h0005);
    pulse(1, B_FCAR, 3);
    do_write(4'h2, 16'h0004, 7'd0);
    do_write(4'h2, 16'h0000, 7'd0);
    do_write(4'h0, 16'h0000, 7'd0);
    do_write(4'h0, 16'hFFFF, 7'd0);
    do_write(4'h1, 16'hFFFF, 7'd0);
    do_read(4'h0, 7'd0, d); chk("R10 counters survive writes", d, 16'h0003);
    do_read(4'h1, 7'd0, d); chk("R10 rx ignores writes", d, 16'h0000);

    // R11 unmapped
    do_read(4'h7, 7'd0, d); chk("R11 unmapped 7", d, 16'h0000);
    do_read(4'hF, 7'd0, d); chk("R11 unmapped F", d, 16'h0000);
    do_read(4'h3, 7'd0, d); chk("R11 expansion reads zero", d, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule